// File: doc/BRIEF.md
# Setup-Frame Exact-Match Destination Filter

This block decides whether an Ethernet receiver keeps an incoming frame, based on its 48-bit destination address. It holds a table of exact addresses (16 by default). The table is loaded from a setup frame that arrives as a byte stream on its own load port, separate from the receive data path. Each 12-byte entry of that frame carries one address. The address is split into three 16-bit halves, and each half is sent twice. Only the first copy of each half is kept; the repeated copy is dropped without being compared.

The receiver presents a destination address with a one-cycle strobe. One cycle later the block returns accept or reject, together with the lowest index of the entry that matched. A common load fills every entry but the last with the station's own address and puts the all-ones broadcast address in the last entry, so that both unicast and broadcast traffic pass.

A setup frame whose byte count differs from 16 × 12 = 192 is thrown away: the table that was already loaded stays in force, and a sticky error flag is raised. Matching is blocked while a load is in progress. Every frame is rejected until the first good load has completed.

Top module: `setup_perfect_filter`

## Requirements
- R1: A setup frame starts with a byte marked `ld_first` and ends with a byte marked `ld_last`. It commits a new table only when it holds exactly N_ENTRIES × 12 bytes (192 by default). A new `ld_first` restarts the count.
- R2: Within each 12-byte entry, the byte offsets map to address octets as follows:
  - offsets 0, 1, 4, 5, 8 and 9 give octets 0 to 5;
  - octet 0 is the first byte on the wire and occupies bits 47:40 of the address;
  - offsets 2, 3, 6, 7, 10 and 11 are ignored whatever their value.
- R3: A lookup compares `lk_addr` against every entry at once. It is accepted when any entry is equal, and `res_index` is the lowest equal entry index.
- R4: The result appears on the clock edge after the `lk_valid` cycle. `res_valid` is high for exactly one cycle per strobe, and `res_index` is 0 on a reject.
- R5: Until the first committed load, `table_ready` is 0 and every lookup is rejected.
- R6: A setup frame whose length is not 192 bytes sets `load_err`, which stays set until reset. The previously committed table is kept unchanged.
- R7: A lookup is rejected in any cycle where a setup frame is open (`load_busy` high) or a load byte is present.
- R8: A load byte with `ld_first` low that arrives while no frame is open is ignored.
- R9: An entry loaded with all ones accepts the broadcast address 48'hFFFF_FFFF_FFFF at that entry's index.
- R10: After reset, `res_valid`, `res_accept`, `load_busy`, `load_err` and `table_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Setup-frame byte present |
| ld_first | input | 1 | Byte is the first of a setup frame |
| ld_last | input | 1 | Byte is the last of a setup frame |
| ld_byte | input | 8 | Setup-frame byte |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address to look up (first wire octet in bits 47:40) |
| res_valid | output | 1 | Lookup result valid |
| res_accept | output | 1 | Address matched an entry |
| res_index | output | 4 | Lowest matching entry index (0 on reject) |
| load_busy | output | 1 | A setup frame is open |
| load_err | output | 1 | Sticky flag: a setup frame had the wrong length |
| table_ready | output | 1 | A table has been committed since reset |

## Verification
The hardest case to reach is a lookup that lands in the middle of a load, for an address the current table would accept. Only that case separates blocking from a plain miss, so the bench first commits a table and then, while a later setup frame is streaming, fires a strobe for an address in the old table and expects a reject. The error path needs similar care. A short frame and an over-long frame follow a good load, and the bench shows that the old entries still match. A good frame sent after that proves the error flag stays set while the table still updates. The setup frames carry inverted values in the duplicate byte slots, so any design that reads the wrong copy of a half-address gives a wrong match.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
  localparam int MAC_W       = 48;
  localparam int ENTRY_BYTES = 12;
  localparam int MAC_BIT_W   = $clog2(MAC_W);

  typedef logic [MAC_W-1:0] mac_t;

  // Offset within an entry carries the first copy of a 16-bit half.
  function automatic logic slot_is_primary(input int off);
    return (off % 4) < 2;
  endfunction

  // Address octet number (0 = first on the wire) for a primary offset.
  function automatic int slot_octet(input int off);
    return (off / 4) * 2 + (off % 2);
  endfunction

  // Low bit position of an octet inside the 48-bit address.
  function automatic int octet_lsb(input int oct);
    return MAC_W - 8 * (oct + 1);
  endfunction
endpackage

// File: rtl/pdf_setup_loader.sv
module pdf_setup_loader
  import pdf_pkg::*;
#(
  parameter int N_ENTRIES   = 16,
  parameter int FRAME_BYTES = N_ENTRIES * ENTRY_BYTES,
  parameter int CNT_W       = $clog2(FRAME_BYTES + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic                   ld_first,
  input  logic                   ld_last,
  input  logic [7:0]             ld_byte,
  output logic                   frame_open,
  output logic                   commit_ev,
  output logic                   bad_ev,
  output mac_t [N_ENTRIES-1:0]   shadow_next
);
  localparam int ENT_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic                 open_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     pos;
  logic [CNT_W-1:0]     pos_nxt;
  logic                 take;
  logic                 end_ev;
  mac_t [N_ENTRIES-1:0] shadow_q;
  mac_t [N_ENTRIES-1:0] shadow_d;
  int                   pos_int;
  int                   ent;
  int                   off;

  always_comb begin
    take    = ld_valid && (ld_first || open_q);
    pos     = ld_first ? '0 : cnt_q;
    pos_nxt = (pos == '1) ? pos : pos + 1'b1;
    pos_int = int'(pos);
    ent     = pos_int / ENTRY_BYTES;
    off     = pos_int % ENTRY_BYTES;
    shadow_d = shadow_q;
    if (take && (pos < CNT_W'(FRAME_BYTES)) && slot_is_primary(off)) begin
      shadow_d[ENT_W'(ent)][MAC_BIT_W'(octet_lsb(slot_octet(off))) +: 8] = ld_byte;
    end
    end_ev    = take && ld_last;
    commit_ev = end_ev && (pos_nxt == CNT_W'(FRAME_BYTES));
    bad_ev    = end_ev && !commit_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      if (take) begin
        cnt_q  <= pos_nxt;
        open_q <= !ld_last;
      end
    end
  end

  assign frame_open  = open_q;
  assign shadow_next = shadow_d;
endmodule

// File: rtl/pdf_entry_table.sv
module pdf_entry_table
  import pdf_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit_ev,
  input  mac_t [N_ENTRIES-1:0] shadow_next,
  output mac_t [N_ENTRIES-1:0] live_tbl,
  output logic                 ready
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_tbl <= '0;
      ready    <= 1'b0;
    end else if (commit_ev) begin
      live_tbl <= shadow_next;
      ready    <= 1'b1;
    end
  end
endmodule

// File: rtl/pdf_match_unit.sv
module pdf_match_unit
  import pdf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_valid,
  input  mac_t                 lk_addr,
  input  mac_t [N_ENTRIES-1:0] live_tbl,
  input  logic                 ready,
  input  logic                 blocked,
  output logic [N_ENTRIES-1:0] hit_vec,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [IDX_W-1:0]     res_index
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = (live_tbl[g] == lk_addr);
  end

  logic             acc_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    acc_d = lk_valid && ready && !blocked && (|hit_vec);
    idx_d = acc_d ? lowest_set(hit_vec) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= lk_valid;
      res_accept <= acc_d;
      res_index  <= idx_d;
    end
  end
endmodule

// File: rtl/setup_perfect_filter.sv
module setup_perfect_filter
  import pdf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic             ld_first,
  input  logic             ld_last,
  input  logic [7:0]       ld_byte,
  input  logic             lk_valid,
  input  logic [47:0]      lk_addr,
  output logic             res_valid,
  output logic             res_accept,
  output logic [IDX_W-1:0] res_index,
  output logic             load_busy,
  output logic             load_err,
  output logic             table_ready
);
  localparam int FRAME_BYTES = N_ENTRIES * ENTRY_BYTES;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 1) + 1;

  logic                 frame_open;
  logic                 commit_ev;
  logic                 bad_ev;
  logic                 blocked;
  logic [N_ENTRIES-1:0] hit_vec;
  mac_t [N_ENTRIES-1:0] shadow_next;
  mac_t [N_ENTRIES-1:0] live_tbl;

  pdf_setup_loader #(
    .N_ENTRIES(N_ENTRIES), .FRAME_BYTES(FRAME_BYTES), .CNT_W(CNT_W)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_first(ld_first),
    .ld_last(ld_last), .ld_byte(ld_byte), .frame_open(frame_open),
    .commit_ev(commit_ev), .bad_ev(bad_ev), .shadow_next(shadow_next)
  );

  pdf_entry_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .commit_ev(commit_ev),
    .shadow_next(shadow_next), .live_tbl(live_tbl), .ready(table_ready)
  );

  assign blocked = frame_open | ld_valid;

  pdf_match_unit #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .live_tbl(live_tbl), .ready(table_ready), .blocked(blocked),
    .hit_vec(hit_vec), .res_valid(res_valid), .res_accept(res_accept),
    .res_index(res_index)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_err <= 1'b0;
    else if (bad_ev) load_err <= 1'b1;
  end

  assign load_busy = frame_open;
endmodule

// File: rtl/pdf_checker.sv
module pdf_checker
  import pdf_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic                 res_valid,
  input logic                 res_accept,
  input logic                 table_ready,
  input logic                 load_err,
  input logic                 blocked,
  input logic                 commit_ev,
  input logic                 bad_ev,
  input logic [N_ENTRIES-1:0] hit_vec,
  input mac_t [N_ENTRIES-1:0] live_tbl
);
  // R4
  res_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R4
  res_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  // R3
  accept_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && (hit_vec == '0) |=> !res_accept);
  // R5
  reject_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !table_ready |=> !res_accept);
  // R7
  reject_while_loading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && blocked |=> !res_accept);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err);
  // R6
  table_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ev |=> $stable(live_tbl));
  // R6
  bad_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ev |=> load_err);
  // R1
  commit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ev |=> table_ready);
endmodule

bind setup_perfect_filter pdf_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
  .res_accept(res_accept), .table_ready(table_ready), .load_err(load_err),
  .blocked(blocked), .commit_ev(commit_ev), .bad_ev(bad_ev),
  .hit_vec(hit_vec), .live_tbl(live_tbl)
);

// File: tb/setup_perfect_filter_tb.sv
module setup_perfect_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_first = 1'b0, ld_last = 1'b0;
  logic [7:0]  ld_byte = '0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_addr = '0;
  logic        res_valid, res_accept, load_busy, load_err, table_ready;
  logic [3:0]  res_index;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  localparam logic [47:0] STA   = 48'h02_10_A0_55_3C_81;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic [47:0] tbl  [16];
  logic [47:0] live [16];
  bit          m_ready = 1'b0;
  bit          m_err   = 1'b0;

  always #2 clk = ~clk;

  setup_perfect_filter u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_first(ld_first),
    .ld_last(ld_last), .ld_byte(ld_byte), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_accept(res_accept),
    .res_index(res_index), .load_busy(load_busy), .load_err(load_err),
    .table_ready(table_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] uniq(input int i);
    return {8'h02, 8'h10, 8'hA0, 8'(i), 8'h3C, 8'(i * 7 + 1)};
  endfunction

  // Wire byte j of a frame built from tbl; duplicate slots inverted if corrupt.
  function automatic logic [7:0] frame_byte(input int j, input bit corrupt);
    int e, o, oct;
    logic [7:0] b;
    if (j >= 192) return 8'h5A;
    e = j / 12; o = j % 12;
    oct = (o / 4) * 2 + (o % 2);
    b = tbl[e][47 - 8 * oct -: 8];
    if (corrupt && (o % 4) >= 2) b = ~b;
    return b;
  endfunction

  function automatic int model_idx(input logic [47:0] a);
    if (!m_ready) return -1;
    for (int i = 0; i < 16; i++) if (live[i] == a) return i;
    return -1;
  endfunction

  task automatic lookup(input logic [47:0] a, input string req);
    int ei;
    ei = model_idx(a);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid == 1'b1, "R4", "res_valid after strobe", 64'(res_valid), 64'd1);
    chk(res_accept == (ei >= 0), req, "accept", 64'(res_accept), 64'(ei >= 0));
    chk(res_index == ((ei >= 0) ? 4'(ei) : 4'd0), req, "index",
        64'(res_index), 64'((ei >= 0) ? ei : 0));
    @(negedge clk);
    chk(res_valid == 1'b0, "R4", "res_valid one cycle", 64'(res_valid), 64'd0);
  endtask

  // Stream a setup frame of len bytes; optional lookup of probe_addr at byte probe_at.
  task automatic send_frame(input int len, input bit corrupt, input int probe_at,
                            input logic [47:0] probe_addr);
    for (int j = 0; j < len; j++) begin
      ld_valid = 1'b1; ld_first = (j == 0); ld_last = (j == len - 1);
      ld_byte = frame_byte(j, corrupt);
      if (j == probe_at) begin lk_valid = 1'b1; lk_addr = probe_addr; end
      @(negedge clk);
      if (j == probe_at) begin
        lk_valid = 1'b0;
        chk(res_valid && !res_accept, "R7", "lookup during load rejected",
            64'(res_accept), 64'd0);
        chk(load_busy == 1'b1, "R7", "load_busy mid frame", 64'(load_busy), 64'd1);
      end
    end
    ld_valid = 1'b0; ld_first = 1'b0; ld_last = 1'b0;
    if (len == 192) begin
      for (int i = 0; i < 16; i++) live[i] = tbl[i];
      m_ready = 1'b1;
    end else m_err = 1'b1;
    chk(load_busy == 1'b0, "R1", "load_busy after last", 64'(load_busy), 64'd0);
    chk(load_err == m_err, "R6", "load_err", 64'(load_err), 64'(m_err));
    chk(table_ready == m_ready, "R5", "table_ready", 64'(table_ready), 64'(m_ready));
  endtask

  task automatic t_reset();
    chk(res_valid == 0 && res_accept == 0, "R10", "result after reset",
        64'({res_valid, res_accept}), 64'd0);
    chk(load_busy == 0 && load_err == 0 && table_ready == 0, "R10", "status after reset",
        64'({load_busy, load_err, table_ready}), 64'd0);
    lookup(STA, "R5");
  endtask

  task automatic t_typical();
    for (int i = 0; i < 15; i++) tbl[i] = STA;
    tbl[15] = BCAST;
    send_frame(192, 1'b0, -1, '0);
    lookup(STA, "R3");
    lookup(BCAST, "R9");
    lookup(48'h02_10_A0_55_3C_80, "R3");
  endtask

  task automatic t_distinct();
    for (int i = 0; i < 16; i++) tbl[i] = uniq(i);
    tbl[11] = uniq(3);
    send_frame(192, 1'b1, 100, STA);
    for (int i = 0; i < 16; i++) if (i != 11) lookup(uniq(i), "R2");
    lookup(uniq(3), "R3");
    lookup(STA, "R3");
  endtask

  task automatic t_stray();
    for (int k = 0; k < 5; k++) begin
      ld_valid = 1'b1; ld_byte = 8'hEE;
      @(negedge clk);
    end
    ld_valid = 1'b0;
    chk(load_busy == 1'b0, "R8", "stray bytes open no frame", 64'(load_busy), 64'd0);
    lookup(uniq(7), "R8");
  endtask

  task automatic t_bad_lengths();
    for (int i = 0; i < 16; i++) tbl[i] = 48'h0A0B_0C0D_0E00 + 48'(i);
    send_frame(100, 1'b0, 40, uniq(7));
    lookup(uniq(7), "R6");
    lookup(tbl[0], "R6");
    send_frame(200, 1'b0, -1, '0);
    lookup(uniq(9), "R6");
    send_frame(192, 1'b0, -1, '0);
    lookup(tbl[5], "R1");
    lookup(uniq(9), "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_typical();
    t_distinct();
    t_stray();
    t_bad_lengths();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule